// File: doc/BRIEF.md
# Complementary Dead-Time Gate Driver Logic

This block turns one pulse-width-modulated command into two non-overlapping gate-drive enables for a pair of complementary switches. The main drive follows the high phase of the command and the auxiliary drive follows the low phase. Each turn-on waits for its own dead time, counted in system clock cycles. A rising command edge drops the auxiliary drive at once and arms the lead timer. A falling edge drops the main drive at once and arms the trail timer.

Either dead time can be switched to zero-voltage mode. In that mode a strobe from an external zero-crossing detector ends the wait early. The timer still ends the wait if no strobe arrives. A low level on the enable input puts the block to sleep: the main drive is held low and the auxiliary driver's output enable is released. After wake-up both drives stay off until the next command edge.

Top module: `cdt_gate_driver`

## Requirements
- R1: The command input is sampled high first at clock edge k. The auxiliary drive is low from edge k+2. The main drive goes high at edge k+2+D, where D is the lead delay captured at edge k+2, unless a zero-voltage strobe or a cancellation comes first.
- R2: The command input is sampled low first at clock edge k. The main drive is low from edge k+2. The auxiliary drive goes high at edge k+2+T, where T is the trail delay captured at edge k+2.
- R3: A captured delay of zero turns the delayed drive on at edge k+2, the same edge that turns the opposite drive off.
- R4: With its mode bit captured as 1 (zero-voltage), a delay wait ends at the clock edge that samples its detect strobe high. With the mode bit captured as 0, the strobe has no effect and the drive waits for the full count.
- R5: The delay values and mode bits are captured only at the edge that starts a wait. Changing them during the wait does not change that wait.
- R6: A command edge of the opposite polarity during a wait cancels the pending turn-on and starts the other wait at once.
- R7: The enable input is sampled low at edge k. From edge k+2 the main drive, the auxiliary drive and the auxiliary output enable are all low.
- R8: On leaving sleep, the output enable rises while both drives are off. Both drives stay off until the next command edge.
- R9: The main and auxiliary drives are never high in the same cycle.
- R10: While reset is asserted, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Asynchronous PWM command |
| drv_enable | input | 1 | Asynchronous enable; low selects sleep |
| lead_dly | input | CNT_W | Dead time before main turn-on, in cycles |
| trail_dly | input | CNT_W | Dead time before auxiliary turn-on, in cycles |
| lead_zv_mode | input | 1 | 1 lets lead_zv_det end the lead wait |
| trail_zv_mode | input | 1 | 1 lets trail_zv_det end the trail wait |
| lead_zv_det | input | 1 | Zero-voltage strobe for the main switch, synchronous |
| trail_zv_det | input | 1 | Zero-voltage strobe for the auxiliary switch, synchronous |
| main_drv | output | 1 | Main switch drive enable |
| aux_drv | output | 1 | Auxiliary switch drive enable |
| aux_oe | output | 1 | Auxiliary driver output enable; low means high impedance |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- the two drives never overlap;
- a command edge switches off the opposite drive on the next edge;
- sleep clears all outputs;
- wake-up starts with both drives off.

Exact dead-time lengths, capture of the settings at the start of a wait, early exit on a zero-voltage strobe, the strobe being ignored in fixed mode, and cancellation depend on counts and history. Only the bench scenarios show these, by comparing every cycle against a cycle model built from the requirements.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [2:0] {
    PH_SLEEP = 3'd0,
    PH_IDLE  = 3'd1,
    PH_LEAD  = 3'd2,
    PH_MAIN  = 3'd3,
    PH_TRAIL = 3'd4,
    PH_AUX   = 3'd5
  } phase_t;

  // Counter preload: a wait of d cycles ends when the counter reads zero.
  function automatic int unsigned dly_reload(int unsigned d);
    return (d == 0) ? 0 : d - 1;
  endfunction

  // A zero delay skips the wait phase entirely.
  function automatic logic dly_skip(int unsigned d);
    return d == 0;
  endfunction

endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cdt_edge_det.sv
module cdt_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;

endmodule

// File: rtl/cdt_delay_timer.sv
module cdt_delay_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] dly,
  input  logic             zv_mode,
  input  logic             zv_det,
  input  logic             run,
  output logic             immediate,
  output logic             fire
);

  logic [CNT_W-1:0] cnt;
  logic             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      mode_q <= 1'b0;
    end else if (start) begin
      cnt    <= CNT_W'(dly_reload(32'(dly)));
      mode_q <= zv_mode;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign immediate = start & dly_skip(32'(dly));
  assign fire      = run & ((cnt == '0) | (mode_q & zv_det));

endmodule

// File: rtl/cdt_gate_driver.sv
module cdt_gate_driver
  import cdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic             drv_enable,
  input  logic [CNT_W-1:0] lead_dly,
  input  logic [CNT_W-1:0] trail_dly,
  input  logic             lead_zv_mode,
  input  logic             trail_zv_mode,
  input  logic             lead_zv_det,
  input  logic             trail_zv_det,
  output logic             main_drv,
  output logic             aux_drv,
  output logic             aux_oe
);

  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_q;
  logic   pwm_s, en_s;
  logic   rise_evt, fall_evt;
  logic   lead_start, trail_start;
  logic   lead_imm, trail_imm;
  logic   lead_fire, trail_fire;
  logic   sleeping;
  phase_t ph, ph_nxt;

  cdt_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d({drv_enable, pwm_in}), .q(sync_q)
  );
  assign pwm_s = sync_q[0];
  assign en_s  = sync_q[1];

  cdt_edge_det i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(pwm_s), .rise(rise_evt), .fall(fall_evt)
  );

  assign sleeping    = (ph == PH_SLEEP);
  assign lead_start  = en_s & ~sleeping & rise_evt;
  assign trail_start = en_s & ~sleeping & fall_evt;

  cdt_delay_timer #(.CNT_W(CNT_W)) i_lead_tmr (
    .clk(clk), .rst_n(rst_n), .start(lead_start), .dly(lead_dly),
    .zv_mode(lead_zv_mode), .zv_det(lead_zv_det), .run(ph == PH_LEAD),
    .immediate(lead_imm), .fire(lead_fire)
  );

  cdt_delay_timer #(.CNT_W(CNT_W)) i_trail_tmr (
    .clk(clk), .rst_n(rst_n), .start(trail_start), .dly(trail_dly),
    .zv_mode(trail_zv_mode), .zv_det(trail_zv_det), .run(ph == PH_TRAIL),
    .immediate(trail_imm), .fire(trail_fire)
  );

  always_comb begin
    ph_nxt = ph;
    if (!en_s)                          ph_nxt = PH_SLEEP;
    else if (sleeping)                  ph_nxt = PH_IDLE;
    else if (rise_evt)                  ph_nxt = lead_imm  ? PH_MAIN : PH_LEAD;
    else if (fall_evt)                  ph_nxt = trail_imm ? PH_AUX  : PH_TRAIL;
    else if (ph == PH_LEAD  && lead_fire)  ph_nxt = PH_MAIN;
    else if (ph == PH_TRAIL && trail_fire) ph_nxt = PH_AUX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_SLEEP;
    else        ph <= ph_nxt;
  end

  assign main_drv = (ph == PH_MAIN);
  assign aux_drv  = (ph == PH_AUX);
  assign aux_oe   = ~sleeping;

endmodule

// File: rtl/cdt_gate_driver_chk.sv
module cdt_gate_driver_chk (
  input logic clk,
  input logic rst_n,
  input logic main_drv,
  input logic aux_drv,
  input logic aux_oe,
  input logic rise_evt,
  input logic fall_evt,
  input logic en_s
);

  // R9
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_drv && aux_drv));

  // R1
  a_r1_rise_kills_aux: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> !aux_drv);

  // R2
  a_r2_fall_kills_main: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !main_drv);

  // R7
  a_r7_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!aux_oe && !main_drv && !aux_drv));

  // R7
  a_r7_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_oe |-> (!main_drv && !aux_drv));

  // R8
  a_r8_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux_oe) |-> (!main_drv && !aux_drv));

  // R10
  always_comb begin
    if (!rst_n) a_r10_reset_quiet: assert (!main_drv && !aux_drv && !aux_oe);
  end

endmodule

bind cdt_gate_driver cdt_gate_driver_chk i_chk (
  .clk(clk), .rst_n(rst_n), .main_drv(main_drv), .aux_drv(aux_drv),
  .aux_oe(aux_oe), .rise_evt(rise_evt), .fall_evt(fall_evt), .en_s(en_s)
);

// File: tb/test_cdt_gate_driver.sv
module test_cdt_gate_driver;

  localparam int CNT_W = 8;
  localparam int M_SLEEP = 0, M_IDLE = 1, M_WL = 2, M_MAIN = 3, M_WT = 4, M_AUX = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b0, drv_enable = 1'b0;
  logic [CNT_W-1:0] lead_dly = '0, trail_dly = '0;
  logic lead_zv_mode = 1'b0, trail_zv_mode = 1'b0;
  logic lead_zv_det = 1'b0, trail_zv_det = 1'b0;
  logic main_drv, aux_drv, aux_oe;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0;
  string scen = "reset";

  cdt_gate_driver #(.CNT_W(CNT_W)) i_cdt_gate_driver (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .drv_enable(drv_enable),
    .lead_dly(lead_dly), .trail_dly(trail_dly),
    .lead_zv_mode(lead_zv_mode), .trail_zv_mode(trail_zv_mode),
    .lead_zv_det(lead_zv_det), .trail_zv_det(trail_zv_det),
    .main_drv(main_drv), .aux_drv(aux_drv), .aux_oe(aux_oe)
  );

  always #4 clk = ~clk;

  // Cycle model built from the requirements: counts the wait upward.
  int    m_ph = M_SLEEP, m_tgt = 0, m_el = 0;
  bit    m_zv = 0, m_p1 = 0, m_p2 = 0, m_p3 = 0, m_e1 = 0, m_e2 = 0;
  bit    m_r, m_f;
  string cause = "R10";

  function automatic bit exp_main(int p); return p == M_MAIN;  endfunction
  function automatic bit exp_aux(int p);  return p == M_AUX;   endfunction
  function automatic bit exp_oe(int p);   return p != M_SLEEP; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = M_SLEEP; m_p1 = 0; m_p2 = 0; m_p3 = 0; m_e1 = 0; m_e2 = 0;
      cause = "R10";
    end else begin
      m_r = m_p2 && !m_p3;
      m_f = !m_p2 && m_p3;
      if (!m_e2) begin
        if (m_ph != M_SLEEP) cause = "R7";
        m_ph = M_SLEEP;
      end else if (m_ph == M_SLEEP) begin
        m_ph = M_IDLE; cause = "R8";
      end else if (m_r) begin
        cause = (m_ph == M_WT) ? "R6" : "R1";
        m_tgt = int'(lead_dly); m_zv = lead_zv_mode; m_el = 0;
        if (m_tgt == 0) begin m_ph = M_MAIN; cause = "R3"; end
        else m_ph = M_WL;
      end else if (m_f) begin
        cause = (m_ph == M_WL) ? "R6" : "R2";
        m_tgt = int'(trail_dly); m_zv = trail_zv_mode; m_el = 0;
        if (m_tgt == 0) begin m_ph = M_AUX; cause = "R3"; end
        else m_ph = M_WT;
      end else if (m_ph == M_WL) begin
        if (m_zv && lead_zv_det) begin m_ph = M_MAIN; cause = "R4"; end
        else if (m_el == m_tgt - 1) m_ph = M_MAIN;
        else m_el++;
      end else if (m_ph == M_WT) begin
        if (m_zv && trail_zv_det) begin m_ph = M_AUX; cause = "R4"; end
        else if (m_el == m_tgt - 1) m_ph = M_AUX;
        else m_el++;
      end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pwm_in;
      m_e2 = m_e1; m_e1 = drv_enable;
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      n_chk++;
      if (main_drv !== exp_main(m_ph) || aux_drv !== exp_aux(m_ph) || aux_oe !== exp_oe(m_ph)) begin
        n_fail++;
        $display("FAIL %s [%s] main/aux/oe actual %b%b%b expected %b%b%b", cause, scen,
                 main_drv, aux_drv, aux_oe, exp_main(m_ph), exp_aux(m_ph), exp_oe(m_ph));
      end
      n_chk++;
      if (main_drv === 1'b1 && aux_drv === 1'b1) begin
        n_fail++;
        $display("FAIL R9 [%s] overlap actual 11 expected not both", scen);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual still running, expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(2);
    chk_on = 1'b1;          // R10: outputs compared while reset still held
    tick(2);
    rst_n = 1'b1;
    tick(4);

    scen = "R8 wake"; drv_enable = 1'b1; tick(6);
    scen = "R1 R2 fixed"; lead_dly = 8'd5; trail_dly = 8'd3;
    pwm_in = 1'b1; tick(15); pwm_in = 1'b0; tick(12);
    scen = "R3 zero"; lead_dly = 8'd0; trail_dly = 8'd0;
    pwm_in = 1'b1; tick(6); pwm_in = 1'b0; tick(6);
    scen = "R4 zv"; lead_dly = 8'd20; trail_dly = 8'd20;
    lead_zv_mode = 1'b1; trail_zv_mode = 1'b0;
    pwm_in = 1'b1; tick(6); lead_zv_det = 1'b1; tick(1); lead_zv_det = 1'b0; tick(6);
    pwm_in = 1'b0; tick(6); trail_zv_det = 1'b1; tick(1); trail_zv_det = 1'b0; tick(25);
    scen = "R5 capture"; lead_zv_mode = 1'b0; lead_dly = 8'd10;
    pwm_in = 1'b1; tick(5); lead_dly = 8'd1; lead_zv_mode = 1'b1; tick(12);
    scen = "R6 cancel"; lead_dly = 8'd12; trail_dly = 8'd12; lead_zv_mode = 1'b0;
    pwm_in = 1'b0; tick(5); pwm_in = 1'b1; tick(5); pwm_in = 1'b0; tick(20);
    scen = "R7 sleep"; pwm_in = 1'b1; tick(20); drv_enable = 1'b0; tick(8);
    scen = "R8 wake high"; drv_enable = 1'b1; tick(10); pwm_in = 1'b0; tick(20);

    scen = "random";
    for (int c = 0; c < 8000; c++) begin
      if ($urandom_range(11, 0) == 0) pwm_in = ~pwm_in;
      if ($urandom_range(39, 0) == 0) begin
        lead_dly  = CNT_W'($urandom_range(15, 0));
        trail_dly = CNT_W'($urandom_range(15, 0));
        lead_zv_mode  = 1'($urandom_range(1, 0));
        trail_zv_mode = 1'($urandom_range(1, 0));
      end
      lead_zv_det  = ($urandom_range(7, 0) == 0);
      trail_zv_det = ($urandom_range(7, 0) == 0);
      if ($urandom_range(299, 0) == 0) drv_enable = 1'b0;
      else if (!drv_enable && $urandom_range(9, 0) == 0) drv_enable = 1'b1;
      tick(1);
    end
    lead_zv_det = 1'b0; trail_zv_det = 1'b0;
    tick(4);
    finish_run();
  end

endmodule